// File: doc/BRIEF.md
# Status-Change Interrupt Aggregator

This block watches two groups of per-channel status lines. One group reports loss of signal and the other reports driver failure. Each group is as wide as the channel count, which is eight by default. Every group is first brought into the block clock domain through two flip-flops. After that, every rise and every fall of a line is latched into a sticky change flag for that channel. The interrupt output `irq_n` is active low. It is pulled low whenever a flag is set and the enable bit for that channel is also set.

Software reaches the block through a plain byte-wide register bus with address, write data, write strobe, read strobe and read data. The bus has no handshake. A write takes effect at the clock edge on which `wr_en` is high. Read data is combinational and is valid during the same cycle as `rd_en`.

The register map is:

| Address | Contents |
|---------|----------|
| 06h | Loss-of-signal enables |
| 07h | Driver-failure enables |
| 08h | Loss-of-signal change flags |
| 09h | Driver-failure change flags |
| 0Ah | Software reset strobe (write only) |

The change flags are cleared by writing a 1 to the bit.

Top module: `stat_irq_agg`

## Requirements
- R1: A rise or a fall on input bit n sets flag bit n of that group: bit n of register 08h for `los_stat_i[n]`, bit n of register 09h for `drv_stat_i[n]`. The flag reads back as 1 after the third rising clock edge that follows the input change. The other group is not affected.
- R2: A flag bit stays at 1 until software clears it. Further toggles and idle cycles do not clear it.
- R3: Writing to 08h or 09h clears each flag bit whose write-data bit is 1. Bits written as 0 keep their value.
- R4: If a change and a clear hit the same flag bit on the same clock edge, the bit ends at 1.
- R5: `irq_n` is 0 exactly when some flag bit is 1 and its enable bit is 1. Otherwise it is 1.
- R6: Flags record changes while their enable bits are 0. Setting the enable later pulls `irq_n` low.
- R7: The enable registers at 06h and 07h store any byte written to them and read it back unchanged.
- R8: A write of any value to 0Ah clears both enable registers and both flag registers at that edge. Reading 0Ah returns 00h.
- R9: After reset all five addresses read 00h and `irq_n` is 1. Inputs that are already 1 while reset is active do not set flags when reset is released.
- R10: Addresses other than 06h–0Ah read 00h, and writes to them change no register. `rdata` is 00h whenever `rd_en` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| los_stat_i | input | CH | Loss-of-signal status, one bit per channel, asynchronous |
| drv_stat_i | input | CH | Driver-failure status, one bit per channel, asynchronous |
| addr | input | AW | Register byte address |
| wdata | input | CH | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe |
| rdata | output | CH | Read data, combinational, 00h when not reading |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench walks every channel of both groups through a rise and then a fall. This catches a design that detects only one edge direction, or one that sets the flag in the wrong group or on the wrong bit. It sweeps all 256 enable values against fixed flag patterns, which exposes an inverted or mis-gated interrupt term. It also lands a clear write on the exact edge where a new change arrives: a design that lets the clear win would lose that event. Two further cases cover the rest. Inputs held high through reset show whether the block reports false changes at start-up. Writes to every unmapped address show whether the decoder aliases any address onto a real register.

// File: rtl/stat_irq_pkg.sv
package stat_irq_pkg;
  timeunit 1ns; timeprecision 1ps;

  localparam int unsigned NGRP = 2;
  localparam int unsigned GRP_LOS = 0;
  localparam int unsigned GRP_DRV = 1;

  localparam logic [7:0] A_LOS_EN = 8'h06;
  localparam logic [7:0] A_DRV_EN = 8'h07;
  localparam logic [7:0] A_LOS_FL = 8'h08;
  localparam logic [7:0] A_DRV_FL = 8'h09;
  localparam logic [7:0] A_SRST   = 8'h0A;

  // Cycles after reset before the synchronizer and the previous-value
  // register both hold real input samples.
  localparam int unsigned FILL_CYCLES = 3;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_LOS_EN,
    SEL_DRV_EN,
    SEL_LOS_FL,
    SEL_DRV_FL,
    SEL_SRST
  } reg_sel_e;
endpackage

// File: rtl/sia_sync2.sv
module sia_sync2 #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  timeunit 1ns; timeprecision 1ps;

  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/sia_chg_track.sv
module sia_chg_track #(
  parameter int unsigned CH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          armed,
  input  logic          srst,
  input  logic [CH-1:0] stat,
  input  logic [CH-1:0] clr,
  output logic [CH-1:0] flags
);
  timeunit 1ns; timeprecision 1ps;

  logic [CH-1:0] prev;
  logic [CH-1:0] chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= stat;
  end

  for (genvar b = 0; b < CH; b++) begin : g_bit
    assign chg[b] = armed & (stat[b] ^ prev[b]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             flags[b] <= 1'b0;
      else if (srst)          flags[b] <= 1'b0;
      else if (chg[b])        flags[b] <= 1'b1;
      else if (clr[b])        flags[b] <= 1'b0;
    end
  end

  p_change_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!srst && chg != '0) |=> ((flags & $past(chg)) == $past(chg)));

  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!srst && clr == '0) |=> ((flags & $past(flags)) == $past(flags)));

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!srst && chg == '0 && clr != '0) |=> ((flags & $past(clr)) == '0));

  p_collide_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!srst && (chg & clr) != '0) |=> ((flags & $past(chg & clr)) == $past(chg & clr)));

  p_srst_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (flags == '0));

  p_quiet_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (flags == '0));
endmodule

// File: rtl/sia_regif.sv
module sia_regif
  import stat_irq_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned CH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [CH-1:0] wdata,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [CH-1:0] los_flags,
  input  logic [CH-1:0] drv_flags,
  output logic [CH-1:0] los_en,
  output logic [CH-1:0] drv_en,
  output logic [CH-1:0] los_clr,
  output logic [CH-1:0] drv_clr,
  output logic          srst,
  output logic [CH-1:0] rdata
);
  timeunit 1ns; timeprecision 1ps;

  reg_sel_e sel;

  always_comb begin
    if      (addr == AW'(A_LOS_EN)) sel = SEL_LOS_EN;
    else if (addr == AW'(A_DRV_EN)) sel = SEL_DRV_EN;
    else if (addr == AW'(A_LOS_FL)) sel = SEL_LOS_FL;
    else if (addr == AW'(A_DRV_FL)) sel = SEL_DRV_FL;
    else if (addr == AW'(A_SRST))   sel = SEL_SRST;
    else                            sel = SEL_NONE;
  end

  assign srst    = wr_en && (sel == SEL_SRST);
  assign los_clr = (wr_en && sel == SEL_LOS_FL) ? wdata : '0;
  assign drv_clr = (wr_en && sel == SEL_DRV_FL) ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      los_en <= '0;
      drv_en <= '0;
    end else if (srst) begin
      los_en <= '0;
      drv_en <= '0;
    end else if (wr_en) begin
      if (sel == SEL_LOS_EN) los_en <= wdata;
      if (sel == SEL_DRV_EN) drv_en <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      unique case (sel)
        SEL_LOS_EN: rdata = los_en;
        SEL_DRV_EN: rdata = drv_en;
        SEL_LOS_FL: rdata = los_flags;
        SEL_DRV_FL: rdata = drv_flags;
        default:    rdata = '0;
      endcase
    end
  end

  p_en_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_LOS_EN) |=> (los_en == $past(wdata)));

  p_srst_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (los_en == '0 && drv_en == '0));

  p_idle_bus_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rdata == '0));

  p_unmapped_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_NONE) |=> $stable(los_en) && $stable(drv_en));
endmodule

// File: rtl/stat_irq_agg.sv
module stat_irq_agg
  import stat_irq_pkg::*;
#(
  parameter int unsigned CH = 8,
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CH-1:0] los_stat_i,
  input  logic [CH-1:0] drv_stat_i,
  input  logic [AW-1:0] addr,
  input  logic [CH-1:0] wdata,
  input  logic          wr_en,
  input  logic          rd_en,
  output logic [CH-1:0] rdata,
  output logic          irq_n
);
  timeunit 1ns; timeprecision 1ps;

  localparam int unsigned FW = $clog2(FILL_CYCLES + 1);

  logic [NGRP-1:0][CH-1:0] stat_raw, stat_s, grp_clr, grp_flags, grp_en;
  logic [FW-1:0]           fill;
  logic                    armed;
  logic                    srst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     fill <= '0;
    else if (!armed) fill <= fill + 1'b1;
  end
  assign armed = (fill == FW'(FILL_CYCLES));

  assign stat_raw[GRP_LOS] = los_stat_i;
  assign stat_raw[GRP_DRV] = drv_stat_i;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    sia_sync2 #(.W(CH)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (stat_raw[g]),
      .q    (stat_s[g])
    );

    sia_chg_track #(.CH(CH)) u_track (
      .clk  (clk),
      .rst_n(rst_n),
      .armed(armed),
      .srst (srst),
      .stat (stat_s[g]),
      .clr  (grp_clr[g]),
      .flags(grp_flags[g])
    );
  end

  sia_regif #(.AW(AW), .CH(CH)) u_regif (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .wdata    (wdata),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .los_flags(grp_flags[GRP_LOS]),
    .drv_flags(grp_flags[GRP_DRV]),
    .los_en   (grp_en[GRP_LOS]),
    .drv_en   (grp_en[GRP_DRV]),
    .los_clr  (grp_clr[GRP_LOS]),
    .drv_clr  (grp_clr[GRP_DRV]),
    .srst     (srst),
    .rdata    (rdata)
  );

  assign irq_n = ~(|(grp_flags[GRP_LOS] & grp_en[GRP_LOS]) |
                   |(grp_flags[GRP_DRV] & grp_en[GRP_DRV]));

  p_irq_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_en == '0) |-> irq_n);

  p_irq_quiet_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_flags == '0) |-> irq_n);
endmodule

// File: tb/stat_irq_agg_tb.sv
module stat_irq_agg_tb;
  timeunit 1ns; timeprecision 1ps;

  localparam int unsigned CH = 8;
  localparam int unsigned AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CH-1:0] los = '0, drv = '0;
  logic [AW-1:0] addr = '0;
  logic [CH-1:0] wdata = '0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [CH-1:0] rdata;
  logic          irq_n;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  stat_irq_agg #(.CH(CH), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .los_stat_i(los), .drv_stat_i(drv),
    .addr(addr), .wdata(wdata), .wr_en(wr_en), .rd_en(rd_en),
    .rdata(rdata), .irq_n(irq_n)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic expect_reg(input string tag, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] v;
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 v = rdata;
    rd_en = 1'b0;
    chk(tag, v, exp);
  endtask

  task automatic expect_irq(input string tag, input logic exp);
    #1 chk(tag, {7'b0, irq_n}, {7'b0, exp});
  endtask

  // change inputs at a falling edge, then wait three rising edges
  task automatic drive(input logic [7:0] l, input logic [7:0] d);
    @(negedge clk);
    los = l; drv = d;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    // R9: inputs held high across reset must not be reported
    los = 8'hFF; drv = 8'hAA;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    for (int a = 6; a <= 10; a++) expect_reg("R9 reset value", 8'(a), 8'h00);
    expect_irq("R9 irq_n after reset", 1'b1);

    // R1: falling edges on every set line
    drive(8'h00, 8'h00);
    expect_reg("R1 fall los", 8'h08, 8'hFF);
    expect_reg("R1 fall drv", 8'h09, 8'hAA);
    wr(8'h08, 8'hFF); wr(8'h09, 8'hFF);
    expect_reg("R3 clear los", 8'h08, 8'h00);
    expect_reg("R3 clear drv", 8'h09, 8'h00);

    // R7: every enable value
    for (int v = 0; v < 256; v++) begin
      wr(8'h06, 8'(v)); wr(8'h07, ~8'(v));
      expect_reg("R7 los enable", 8'h06, 8'(v));
      expect_reg("R7 drv enable", 8'h07, ~8'(v));
    end
    wr(8'h06, 8'h00); wr(8'h07, 8'h00);

    // R1/R3: each channel, each group, both directions
    for (int g = 0; g < 2; g++) begin
      for (int b = 0; b < CH; b++) begin
        logic [7:0] m, fa, oa;
        m  = 8'(1 << b);
        fa = (g == 0) ? 8'h08 : 8'h09;
        oa = (g == 0) ? 8'h09 : 8'h08;
        for (int dir = 0; dir < 2; dir++) begin
          if (g == 0) drive(dir == 0 ? m : 8'h00, 8'h00);
          else        drive(8'h00, dir == 0 ? m : 8'h00);
          expect_reg("R1 channel flag", fa, m);
          expect_reg("R1 other group untouched", oa, 8'h00);
          wr(fa, m);
          expect_reg("R3 channel clear", fa, 8'h00);
        end
      end
    end

    // R2: sticky across idle and across a second toggle
    drive(8'h81, 8'h00);
    repeat (20) @(negedge clk);
    expect_reg("R2 held over idle", 8'h08, 8'h81);
    drive(8'h00, 8'h00);
    expect_reg("R2 held over re-toggle", 8'h08, 8'h81);
    wr(8'h08, 8'h00);
    expect_reg("R3 zero write keeps", 8'h08, 8'h81);
    wr(8'h08, 8'h01);
    expect_reg("R3 partial clear", 8'h08, 8'h80);
    wr(8'h08, 8'h80);
    expect_reg("R3 final clear", 8'h08, 8'h00);

    // R6/R5: flags recorded while disabled, then enable sweep
    drive(8'hA5, 8'h3C);
    expect_reg("R6 los recorded disabled", 8'h08, 8'hA5);
    expect_reg("R6 drv recorded disabled", 8'h09, 8'h3C);
    expect_irq("R6 irq_n high while disabled", 1'b1);
    for (int e = 0; e < 256; e++) begin
      wr(8'h06, 8'(e));
      expect_irq("R5 los enable sweep", (8'(e) & 8'hA5) == 8'h00);
    end
    wr(8'h06, 8'h00);
    for (int e = 0; e < 256; e++) begin
      wr(8'h07, 8'(e));
      expect_irq("R5 drv enable sweep", (8'(e) & 8'h3C) == 8'h00);
    end
    wr(8'h06, 8'hFF); wr(8'h07, 8'hFF);
    expect_irq("R5 both enabled", 1'b0);
    wr(8'h08, 8'hA5);
    expect_irq("R5 drv still pending", 1'b0);
    wr(8'h09, 8'h3C);
    expect_irq("R5 all cleared", 1'b1);

    // R4: clear lands on the same edge as a new change
    drive(los ^ 8'h80, drv);
    expect_reg("R4 setup", 8'h08, 8'h80);
    @(negedge clk);
    los = los ^ 8'h01;
    repeat (2) @(negedge clk);
    addr = 8'h08; wdata = 8'hFF; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    expect_reg("R4 set wins over clear", 8'h08, 8'h01);

    // R8: software reset
    drive(los ^ 8'h0F, drv ^ 8'hF0);
    wr(8'h06, 8'hFF); wr(8'h07, 8'hFF);
    expect_irq("R8 pending before reset", 1'b0);
    wr(8'h0A, 8'h5A);
    for (int a = 6; a <= 10; a++) expect_reg("R8 after soft reset", 8'(a), 8'h00);
    expect_irq("R8 irq_n after soft reset", 1'b1);

    // R10: unmapped writes and reads
    wr(8'h06, 8'h12); wr(8'h07, 8'h34);
    drive(los ^ 8'h0F, drv);
    for (int a = 0; a < 256; a++)
      if (a < 6 || a > 10) wr(8'(a), 8'hFF);
    for (int a = 0; a < 256; a++)
      if (a < 6 || a > 10) expect_reg("R10 unmapped read", 8'(a), 8'h00);
    expect_reg("R10 los enable kept", 8'h06, 8'h12);
    expect_reg("R10 drv enable kept", 8'h07, 8'h34);
    expect_reg("R10 los flags kept", 8'h08, 8'h0F);
    expect_reg("R10 drv flags kept", 8'h09, 8'h00);
    @(negedge clk);
    addr = 8'h06; rd_en = 1'b0;
    #1 chk("R10 idle bus", rdata, 8'h00);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule